// File: doc/BRIEF.md
# Byte-Stream CRC16 Coprocessor

This block computes a 16-bit cyclic redundancy check over a stream of bytes drained from an adjacent byte buffer, as used when building and checking contactless-card frames. A start strobe loads one of four fixed presets, picked by a 2-bit select. The block then takes one byte per cycle from the buffer through a valid/ready handshake until the buffer reports empty. There is no limit on the byte count.

The running remainder is shown at all times as a high byte and a low byte. When a run finishes, a one-cycle done pulse is issued and a sticky interrupt-request flag is set. The flag reaches the interrupt output only while the enable input is high, and the next accepted start clears it.

The controller has three states. IDLE waits for a start. RUN consumes bytes. DONE lasts one cycle and signals completion. The transitions are:
- IDLE→RUN on start.
- RUN→RUN while bytes arrive or the buffer is merely stalled.
- RUN→DONE when the buffer is empty and no byte is offered.
- DONE→IDLE unconditionally.

Top module: `crc16_copro`

## Requirements
- R1: A start accepted in IDLE loads the remainder with the preset picked by the select: 00→0000h, 01→6363h, 10→A671h, 11→FFFFh. The loaded value is visible in the cycle after the start.
- R2: Each accepted byte updates the remainder with polynomial x^16+x^12+x^5+1 in reflected form (constant 8408h, right shift), least significant data bit first, with no final inversion. With preset 6363h, the bytes 00h,00h give 1EA0h.
- R3: The high result output carries remainder bits 15..8 and the low result output carries bits 7..0.
- R4: In RUN, the ready output is high and a byte is consumed in every cycle where valid is high. Runs of any length (at least 100 bytes) are supported.
- R5: Busy is high from the cycle after an accepted start until the cycle in which RUN sees the buffer empty with no byte offered. A cycle with neither a byte nor empty keeps the run going.
- R6: Done is high for exactly one cycle, the cycle after RUN ends. The interrupt-request flag is set in that same cycle.
- R7: The interrupt output equals the flag gated by the enable input. The flag stays set until the next accepted start clears it.
- R8: A start seen in RUN or DONE is ignored: the remainder is not reloaded and the run continues.
- R9: Outside RUN, ready is low, offered bytes are not consumed, and the remainder holds its value.
- R10: After reset, the result is 0000h, and busy, done, ready and the flag are all low.
- R11: When valid and empty are both high in RUN, the byte is consumed and the run continues. The run ends only on a later cycle with empty high and valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe |
| preset_sel_i | input | 2 | Preset select, sampled with start |
| byte_i | input | 8 | Byte from the buffer |
| byte_valid_i | input | 1 | Byte present on byte_i |
| byte_ready_o | output | 1 | Block takes the byte this cycle |
| buf_empty_i | input | 1 | Buffer holds no more bytes |
| irq_en_i | input | 1 | Enable for the interrupt output |
| crc_hi_o | output | 8 | Remainder bits 15..8 |
| crc_lo_o | output | 8 | Remainder bits 7..0 |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| irq_flag_o | output | 1 | Sticky completion request flag |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The hardest situations to reach from the ports are the edges of a run. One is a start arriving mid-run while the buffer is stalled (neither empty nor valid). The other is a final byte offered in the same cycle that the buffer already flags empty. The bench reaches both with directed sequences. It drives a stall cycle that carries a start with a different preset, then checks that the final remainder matches the original preset. It drives valid and empty together, then checks that busy persists for one more cycle and that the byte is included in the remainder.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

    localparam int CRC_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } crc_state_e;

    // Preset selection table (select code -> initial remainder)
    function automatic logic [CRC_W-1:0] preset_of(input logic [1:0] sel);
        logic [CRC_W-1:0] v;
        unique case (sel)
            2'b00:   v = 16'h0000;
            2'b01:   v = 16'h6363;
            2'b10:   v = 16'hA671;
            default: v = 16'hFFFF;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/crc16_step.sv
// One byte of reflected CRC: a chain of single-bit stages, LSB of data first.
module crc16_step #(
    parameter int          CRC_W  = 16,
    parameter int          DATA_W = 8,
    parameter logic [15:0] POLY_R = 16'h8408
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);

    localparam int STAGES = DATA_W + 1;

    logic [CRC_W-1:0] chain [STAGES];

    assign chain[0] = crc_in;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic fb;
        assign fb = chain[b][0] ^ data_in[b];
        assign chain[b+1] = (chain[b] >> 1) ^ (fb ? POLY_R[CRC_W-1:0] : '0);
    end

    assign crc_out = chain[DATA_W];

endmodule

// File: rtl/crc16_ctrl.sv
module crc16_ctrl
    import crc16_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       byte_valid_i,
    input  logic       buf_empty_i,
    output logic       accept_start_o,
    output logic       take_byte_o,
    output logic       run_end_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       byte_ready_o
);

    crc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN:  if (buf_empty_i && !byte_valid_i) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept_start_o = 1'b0;
        take_byte_o    = 1'b0;
        run_end_o      = 1'b0;
        busy_o         = 1'b0;
        done_o         = 1'b0;
        byte_ready_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: accept_start_o = start_i;
            ST_RUN: begin
                busy_o       = 1'b1;
                byte_ready_o = 1'b1;
                take_byte_o  = byte_valid_i;
                run_end_o    = buf_empty_i && !byte_valid_i;
            end
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_follows_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_end_o |=> done_o && !busy_o);

    assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accept_start_o |=> busy_o);

    assert_valid_empty_continue_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && byte_valid_i) |=> busy_o);

endmodule

// File: rtl/crc16_irq.sv
module crc16_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic flag_o,
    output logic irq_o
);

    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (set_i)  flag_q <= 1'b1;
        else if (clr_i)  flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & en_i;

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);

endmodule

// File: rtl/crc16_copro.sv
module crc16_copro
    import crc16_pkg::*;
#(
    parameter int          DATA_W = BYTE_W,
    parameter logic [15:0] POLY_R = 16'h8408
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        preset_sel_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              byte_valid_i,
    output logic              byte_ready_o,
    input  logic              buf_empty_i,
    input  logic              irq_en_i,
    output logic [7:0]        crc_hi_o,
    output logic [7:0]        crc_lo_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              irq_flag_o,
    output logic              irq_o
);

    localparam int HALF = CRC_W / 2;

    logic             accept_start, take_byte, run_end;
    logic [CRC_W-1:0] crc_q, crc_next;

    crc16_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .byte_valid_i  (byte_valid_i),
        .buf_empty_i   (buf_empty_i),
        .accept_start_o(accept_start),
        .take_byte_o   (take_byte),
        .run_end_o     (run_end),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .byte_ready_o  (byte_ready_o)
    );

    crc16_step #(
        .CRC_W (CRC_W),
        .DATA_W(DATA_W),
        .POLY_R(POLY_R)
    ) u_step (
        .crc_in (crc_q),
        .data_in(byte_i),
        .crc_out(crc_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            crc_q <= '0;
        else if (accept_start) crc_q <= preset_of(preset_sel_i);
        else if (take_byte)    crc_q <= crc_next;
    end

    crc16_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (run_end),
        .clr_i (accept_start),
        .en_i  (irq_en_i),
        .flag_o(irq_flag_o),
        .irq_o (irq_o)
    );

    assign crc_hi_o = crc_q[CRC_W-1:HALF];
    assign crc_lo_o = crc_q[HALF-1:0];

    assert_preset_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        accept_start |=> {crc_hi_o, crc_lo_o} == preset_of($past(preset_sel_i)));

    assert_hold_outside_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !accept_start) |=> $stable(crc_q));

    assert_flag_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> irq_flag_o);

endmodule

// File: tb/tb_crc16_copro.sv
module tb_crc16_copro;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] preset_sel_i = 2'b00;
    logic [7:0] byte_i = 8'h00;
    logic       byte_valid_i = 1'b0;
    logic       buf_empty_i = 1'b1;
    logic       irq_en_i = 1'b0;
    logic       byte_ready_o, busy_o, done_o, irq_flag_o, irq_o;
    logic [7:0] crc_hi_o, crc_lo_o;

    int total = 0;
    int bad = 0;
    logic [7:0] bmem [0:127];

    always #2.5 clk = ~clk;

    crc16_copro dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .preset_sel_i(preset_sel_i),
        .byte_i(byte_i), .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o),
        .buf_empty_i(buf_empty_i), .irq_en_i(irq_en_i), .crc_hi_o(crc_hi_o),
        .crc_lo_o(crc_lo_o), .busy_o(busy_o), .done_o(done_o),
        .irq_flag_o(irq_flag_o), .irq_o(irq_o)
    );

    localparam int NV = 6;
    localparam logic [1:0]  V_SEL [NV] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b01, 2'b10};
    localparam int          V_N   [NV] = '{0, 0, 0, 0, 4, 3};
    localparam logic [31:0] V_DAT [NV] = '{32'h0, 32'h0, 32'h0, 32'h0,
                                           32'h44332211, 32'h00C3A55A};

    function automatic logic [15:0] sel_preset(input logic [1:0] s);
        case (s)
            2'b00: return 16'h0000;
            2'b01: return 16'h6363;
            2'b10: return 16'hA671;
            default: return 16'hFFFF;
        endcase
    endfunction

    // Reference: MSB-first CCITT on bit-reversed operands, result reversed back
    function automatic logic [15:0] ref_crc(input logic [15:0] pre, input int n);
        logic [15:0] r;
        logic [7:0]  x;
        logic        fb;
        for (int i = 0; i < 16; i++) r[15-i] = pre[i];
        for (int k = 0; k < n; k++) begin
            for (int i = 0; i < 8; i++) x[7-i] = bmem[k][i];
            for (int i = 7; i >= 0; i--) begin
                fb = r[15] ^ x[i];
                r  = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
            end
        end
        for (int i = 0; i < 16; i++) ref_crc[15-i] = r[i];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one full run; bytes come from bmem. Leaves the block in IDLE.
    task automatic run_frame(input logic [1:0] sel, input int n, input string tag);
        logic [15:0] exp;
        exp = ref_crc(sel_preset(sel), n);
        @(negedge clk);
        start_i = 1'b1; preset_sel_i = sel; buf_empty_i = (n == 0);
        @(negedge clk);
        start_i = 1'b0;
        chk({tag, " R5 busy after start"}, busy_o, 1);
        chk({tag, " R1 preset loaded"}, {crc_hi_o, crc_lo_o}, sel_preset(sel));
        chk({tag, " R7 flag cleared by start"}, irq_flag_o, 0);
        for (int k = 0; k < n; k++) begin
            byte_valid_i = 1'b1; byte_i = bmem[k]; buf_empty_i = 1'b0;
            if (k == 0) chk({tag, " R4 ready in run"}, byte_ready_o, 1);
            @(negedge clk);
        end
        byte_valid_i = 1'b0; buf_empty_i = 1'b1;
        @(negedge clk);
        chk({tag, " R6 done pulse"}, done_o, 1);
        chk({tag, " R6 flag set"}, irq_flag_o, 1);
        chk({tag, " R5 busy low at end"}, busy_o, 0);
        chk({tag, " R2 R3 result"}, {crc_hi_o, crc_lo_o}, exp);
        @(negedge clk);
        chk({tag, " R6 done one cycle"}, done_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] hold;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 result", {crc_hi_o, crc_lo_o}, 16'h0000);
        chk("R10 busy/done/ready/flag", {busy_o, done_o, byte_ready_o, irq_flag_o}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < 4; k++) bmem[k] = V_DAT[v][8*k +: 8];
            run_frame(V_SEL[v], V_N[v], $sformatf("vec%0d", v));
        end

        // R2 known value: preset 6363h over 00h 00h gives 1EA0h; R3 byte split
        bmem[0] = 8'h00; bmem[1] = 8'h00;
        run_frame(2'b01, 2, "known");
        chk("R2 known hi byte R3", crc_hi_o, 8'h1E);
        chk("R2 known lo byte R3", crc_lo_o, 8'hA0);

        // R4 long stream
        for (int k = 0; k < 100; k++) bmem[k] = 8'(k * 7 + 3);
        run_frame(2'b11, 100, "long R4");

        // R9 idle bytes ignored
        hold = {crc_hi_o, crc_lo_o};
        byte_valid_i = 1'b1; byte_i = 8'hFF; buf_empty_i = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R9 ready low idle", byte_ready_o, 0);
        end
        chk("R9 result held idle", {crc_hi_o, crc_lo_o}, hold);
        byte_valid_i = 1'b0; buf_empty_i = 1'b1;

        // R7 gating of interrupt output
        chk("R7 irq gated off", irq_o, 0);
        irq_en_i = 1'b1; #1;
        chk("R7 irq gated on", irq_o, 1);
        irq_en_i = 1'b0;

        // R8 start while busy ignored (during a stall cycle)
        bmem[0] = 8'h55; bmem[1] = 8'hAA;
        @(negedge clk);
        start_i = 1'b1; preset_sel_i = 2'b01; buf_empty_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        byte_valid_i = 1'b1; byte_i = 8'h55;
        @(negedge clk);
        byte_valid_i = 1'b0; start_i = 1'b1; preset_sel_i = 2'b11;
        @(negedge clk);
        start_i = 1'b0;
        chk("R8 busy after stall start", busy_o, 1);
        byte_valid_i = 1'b1; byte_i = 8'hAA;
        @(negedge clk);
        byte_valid_i = 1'b0; buf_empty_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        chk("R8 done", done_o, 1);
        @(negedge clk);
        start_i = 1'b0;
        chk("R8 result not reloaded", {crc_hi_o, crc_lo_o}, ref_crc(16'h6363, 2));
        chk("R8 start in DONE ignored", busy_o, 0);

        // R11 valid and empty together
        bmem[0] = 8'h31;
        @(negedge clk);
        start_i = 1'b1; preset_sel_i = 2'b10; buf_empty_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        byte_valid_i = 1'b1; byte_i = 8'h31;
        @(negedge clk);
        byte_valid_i = 1'b0;
        chk("R11 busy continues", busy_o, 1);
        chk("R11 byte consumed", {crc_hi_o, crc_lo_o}, ref_crc(16'hA671, 1));
        @(negedge clk);
        chk("R11 done after", done_o, 1);
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule